// File: doc/BRIEF.md
# ATA Device-Select Command Sequencer

This block sits on the host side of a shared ATA bus with up to two drives. It runs the register-level handshake that issues one command. A single-cycle `start` pulse supplies these fields, and the block latches them:

- the target drive;
- the addressing mode;
- a 27-bit block address;
- the sector count;
- the features byte;
- the command code.

The block then drives one-cycle read and write strobes, with a register-select code, toward an abstract drive register port. That port returns status one cycle after each read strobe.

The sequence runs in this order:

1. Wait until the drive is neither busy nor requesting data.
2. Select the drive.
3. Hold off for a fixed settle time. This time is given in nanoseconds and is rounded up to whole cycles of the selected 66 or 132 MHz clock.
4. Wait until the drive is ready again.
5. Write the parameter registers and then the command.
6. Wait for the drive interrupt, then read status once.

The block ends with a `done` pulse together with either `accepted` or `cmd_error`. If a status poll phase runs past a programmable cycle limit, the block ends with a `timeout` pulse instead.

Top module: `ata_cmd_seq`

## Requirements
- R1: After reset, all of the following are 0: `busy`, `reg_rd`, `reg_wr`, `done`, `accepted`, `cmd_error` and `timeout`.
- R2: Starting and busy behaviour:
  - A `start` pulse seen while `busy` is 0 makes `busy` 1 in the next cycle.
  - `busy` stays 1 until the cycle in which `done` or `timeout` pulses.
  - A `start` pulse seen while `busy` is 1 has no effect on the strobes, the written data or the result.
- R3: First poll phase:
  - The first strobe after start is a read of the alternate status register (select code 8).
  - Such reads repeat until one returns bit 7 (BSY) = 0 and bit 3 (DRQ) = 0. Either bit alone keeps the block polling.
  - No write occurs before that read.
  - Read data is taken in the cycle after the read strobe.
- R4: The first write is to the device/head register (select code 6). Its data is {1, addressing mode, 1, device, 4'b0000}, where addressing mode 1 means LBA.
- R5: The next status read strobe comes exactly N+1 cycles after the device/head write strobe. N is ceil(400 ns × f): 27 for the 66 MHz setting (`clk_fast`=0) and 53 for the 132 MHz setting (`clk_fast`=1).
- R6: `clk_fast` is sampled only on an accepted start. Changing it while busy does not change the settle wait.
- R7: Second poll phase and parameter writes:
  - After the wait, the block repeats the R3 poll.
  - It then writes, on consecutive cycles: features (code 1), sector count (code 2), address bits 7:0 (code 3), 15:8 (code 4), 23:16 (code 5).
  - Next it writes device/head (code 6) as {1, mode, 1, device, 0, address bits 26:24}.
  - Last it writes the command (code 7).
- R8: Interrupt and result:
  - After the command write, the block waits for `drv_irq` and then performs one status read (code 8).
  - If bit 0 (ERR) of that status is 1, `done` and `cmd_error` pulse for one cycle. Otherwise `done` and `accepted` pulse for one cycle.
  - `busy` then drops.
- R9: Poll timeout:
  - In each poll phase a cycle counter starts at 0 on entry.
  - When a status check finds the drive not ready and the counter is at least `poll_limit`, `timeout` pulses for one cycle, `done` stays 0 and `busy` drops.
  - No further strobes follow.
- R10: `reg_rd` and `reg_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (66 or 132 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle command request |
| dev_sel | input | 1 | Target drive, 0 or 1 |
| lba_mode | input | 1 | 1 = LBA addressing, 0 = CHS-style |
| lba_addr | input | 27 | Block address |
| sect_cnt | input | 8 | Sector count register value |
| feat_val | input | 8 | Features register value |
| cmd_code | input | 8 | Command register value |
| clk_fast | input | 1 | 1 = 132 MHz clock, 0 = 66 MHz clock |
| poll_limit | input | 16 | Poll phase timeout in cycles |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_sel | output | 4 | Register select code |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Status returned the cycle after a read strobe |
| drv_irq | input | 1 | Drive interrupt |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| accepted | output | 1 | Finished without error (with `done`) |
| cmd_error | output | 1 | Finished with ERR set (with `done`) |
| timeout | output | 1 | Poll phase expired pulse |

## Verification
The hardest case to reach is a timeout in the second poll phase. The drive must report ready before selection and then stay busy for good after it, so that exactly one write is seen before the abort. The bench's drive model keeps separate busy-read counters for the phases before and after the device/head write, and it can set either counter to never run out. The same model alternates BSY-only and DRQ-only status values, so each bit is shown to block progress on its own. A second start pulse, with changed fields and a flipped clock select, is injected during the settle wait to show that the running command is unaffected.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_P1_RD, S_P1_CHK, S_SEL, S_SETTLE, S_P2_RD, S_P2_CHK,
    S_FEAT, S_SCNT, S_LBA0, S_LBA1, S_LBA2, S_DEV2, S_CMD,
    S_IRQ, S_IRQ_RD, S_IRQ_CHK
  } seq_state_t;

  localparam logic [3:0] SEL_FEAT  = 4'd1;
  localparam logic [3:0] SEL_SCNT  = 4'd2;
  localparam logic [3:0] SEL_LBA0  = 4'd3;
  localparam logic [3:0] SEL_LBA1  = 4'd4;
  localparam logic [3:0] SEL_LBA2  = 4'd5;
  localparam logic [3:0] SEL_DEVHD = 4'd6;
  localparam logic [3:0] SEL_CMD   = 4'd7;
  localparam logic [3:0] SEL_ALTST = 4'd8;

  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;
  localparam int ST_ERR = 0;

  // minimum time in ns -> whole clock cycles, rounded up
  function automatic int cycles_for_ns(int ns, int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/ata_settle_timer.sv
module ata_settle_timer #(
  parameter int SLOW_CYC = 27,
  parameter int FAST_CYC = 53,
  localparam int CW = $clog2(FAST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic fast,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = cnt_q - CW'(1);
    if (load) cnt_d = fast ? CW'(FAST_CYC - 1) : CW'(SLOW_CYC - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ata_poll_watchdog.sv
module ata_poll_watchdog #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = !run || (cnt_q != '1);
    cnt_d  = run ? cnt_q + TO_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/ata_cmd_seq.sv
module ata_cmd_seq
  import ata_seq_pkg::*;
#(
  parameter int SETTLE_NS = 400,
  parameter int SLOW_MHZ  = 66,
  parameter int FAST_MHZ  = 132,
  parameter int LBA_W     = 27,
  parameter int TO_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dev_sel,
  input  logic             lba_mode,
  input  logic [LBA_W-1:0] lba_addr,
  input  logic [7:0]       sect_cnt,
  input  logic [7:0]       feat_val,
  input  logic [7:0]       cmd_code,
  input  logic             clk_fast,
  input  logic [TO_W-1:0]  poll_limit,
  output logic             reg_rd,
  output logic             reg_wr,
  output logic [3:0]       reg_sel,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata,
  input  logic             drv_irq,
  output logic             busy,
  output logic             done,
  output logic             accepted,
  output logic             cmd_error,
  output logic             timeout
);

  localparam int SLOW_CYC = cycles_for_ns(SETTLE_NS, SLOW_MHZ);
  localparam int FAST_CYC = cycles_for_ns(SETTLE_NS, FAST_MHZ);
  localparam int HI_W     = LBA_W - 24;

  seq_state_t state_q, state_d;

  logic             dev_q, mode_q, fast_q;
  logic [LBA_W-1:0] lba_q;
  logic [7:0]       scnt_q, feat_q, cmd_q;
  logic             take;

  logic done_d, acc_d, err_d, to_d;
  logic done_q, acc_q, err_q, to_q;

  logic in_poll, poll_exp, settle_exp, ready, is_chk;
  logic [3:0] hi_nib;
  logic [7:0] devhd0, devhd1;
  logic unused_stat;

  assign take        = start && (state_q == S_IDLE);
  assign ready       = !reg_rdata[ST_BSY] && !reg_rdata[ST_DRQ];
  assign is_chk      = (state_q == S_P1_CHK) || (state_q == S_P2_CHK);
  assign in_poll     = is_chk || (state_q == S_P1_RD) || (state_q == S_P2_RD);
  assign hi_nib      = 4'(lba_q[LBA_W-1:LBA_W-HI_W]);
  assign devhd0      = {1'b1, mode_q, 1'b1, dev_q, 4'b0000};
  assign devhd1      = {1'b1, mode_q, 1'b1, dev_q, hi_nib};
  assign unused_stat = ^{reg_rdata[6:4], reg_rdata[2:1]};

  ata_poll_watchdog #(.TO_W(TO_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run(in_poll), .limit(poll_limit), .expired(poll_exp)
  );

  ata_settle_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(state_q == S_SEL), .fast(fast_q),
    .run(state_q == S_SETTLE), .expired(settle_exp)
  );

  // next state
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    acc_d   = 1'b0;
    err_d   = 1'b0;
    to_d    = 1'b0;
    unique case (state_q)
      S_IDLE:    if (start) state_d = S_P1_RD;
      S_P1_RD:   state_d = S_P1_CHK;
      S_P1_CHK:  if (ready) state_d = S_SEL;
                 else if (poll_exp) begin state_d = S_IDLE; to_d = 1'b1; end
                 else state_d = S_P1_RD;
      S_SEL:     state_d = S_SETTLE;
      S_SETTLE:  if (settle_exp) state_d = S_P2_RD;
      S_P2_RD:   state_d = S_P2_CHK;
      S_P2_CHK:  if (ready) state_d = S_FEAT;
                 else if (poll_exp) begin state_d = S_IDLE; to_d = 1'b1; end
                 else state_d = S_P2_RD;
      S_FEAT:    state_d = S_SCNT;
      S_SCNT:    state_d = S_LBA0;
      S_LBA0:    state_d = S_LBA1;
      S_LBA1:    state_d = S_LBA2;
      S_LBA2:    state_d = S_DEV2;
      S_DEV2:    state_d = S_CMD;
      S_CMD:     state_d = S_IRQ;
      S_IRQ:     if (drv_irq) state_d = S_IRQ_RD;
      S_IRQ_RD:  state_d = S_IRQ_CHK;
      S_IRQ_CHK: begin
        state_d = S_IDLE;
        done_d  = 1'b1;
        err_d   = reg_rdata[ST_ERR];
        acc_d   = !reg_rdata[ST_ERR];
      end
      default:   state_d = S_IDLE;
    endcase
  end

  // strobe decode
  always_comb begin
    reg_rd    = 1'b0;
    reg_wr    = 1'b0;
    reg_sel   = '0;
    reg_wdata = '0;
    unique case (state_q)
      S_P1_RD, S_P2_RD, S_IRQ_RD: begin reg_rd = 1'b1; reg_sel = SEL_ALTST; end
      S_SEL:  begin reg_wr = 1'b1; reg_sel = SEL_DEVHD; reg_wdata = devhd0; end
      S_FEAT: begin reg_wr = 1'b1; reg_sel = SEL_FEAT;  reg_wdata = feat_q; end
      S_SCNT: begin reg_wr = 1'b1; reg_sel = SEL_SCNT;  reg_wdata = scnt_q; end
      S_LBA0: begin reg_wr = 1'b1; reg_sel = SEL_LBA0;  reg_wdata = lba_q[7:0]; end
      S_LBA1: begin reg_wr = 1'b1; reg_sel = SEL_LBA1;  reg_wdata = lba_q[15:8]; end
      S_LBA2: begin reg_wr = 1'b1; reg_sel = SEL_LBA2;  reg_wdata = lba_q[23:16]; end
      S_DEV2: begin reg_wr = 1'b1; reg_sel = SEL_DEVHD; reg_wdata = devhd1; end
      S_CMD:  begin reg_wr = 1'b1; reg_sel = SEL_CMD;   reg_wdata = cmd_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      err_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      acc_q   <= acc_d;
      err_q   <= err_d;
      to_q    <= to_d;
    end
  end

  // command fields, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= 1'b0;
      mode_q <= 1'b0;
      fast_q <= 1'b0;
      lba_q  <= '0;
      scnt_q <= '0;
      feat_q <= '0;
      cmd_q  <= '0;
    end else if (take) begin
      dev_q  <= dev_sel;
      mode_q <= lba_mode;
      fast_q <= clk_fast;
      lba_q  <= lba_addr;
      scnt_q <= sect_cnt;
      feat_q <= feat_val;
      cmd_q  <= cmd_code;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign accepted  = acc_q;
  assign cmd_error = err_q;
  assign timeout   = to_q;

endmodule

// File: rtl/ata_cmd_seq_chk.sv
module ata_cmd_seq_chk
  import ata_seq_pkg::*;
#(
  parameter int SETTLE_NS = 400,
  parameter int SLOW_MHZ  = 66,
  parameter int FAST_MHZ  = 132
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       clk_fast,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [3:0] reg_sel,
  input logic       done,
  input logic       accepted,
  input logic       cmd_error,
  input logic       timeout
);

  localparam int GAP_SLOW = cycles_for_ns(SETTLE_NS, SLOW_MHZ) + 1;
  localparam int GAP_FAST = cycles_for_ns(SETTLE_NS, FAST_MHZ) + 1;

  logic       fast_seen, armed;
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_seen <= 1'b0;
      armed     <= 1'b0;
      gap       <= '0;
    end else begin
      if (start && !busy) fast_seen <= clk_fast;
      if (reg_wr && reg_sel == SEL_DEVHD) begin
        armed <= 1'b1;
        gap   <= 8'd1;
      end else begin
        if (armed && gap != 8'hFF) gap <= gap + 8'd1;
        if (reg_rd || reg_wr) armed <= 1'b0;
      end
    end
  end

  p_excl_strobes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || timeout));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_rd && !reg_wr));

  p_settle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_rd) |-> (gap == (fast_seen ? 8'(GAP_FAST) : 8'(GAP_SLOW))));

  p_result_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (accepted ^ cmd_error));

  p_result_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted || cmd_error) |-> done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_timeout_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!done && !busy));

endmodule

bind ata_cmd_seq ata_cmd_seq_chk #(
  .SETTLE_NS(SETTLE_NS), .SLOW_MHZ(SLOW_MHZ), .FAST_MHZ(FAST_MHZ)
) chk_i (.*);

// File: tb/ata_cmd_seq_tb.sv
module ata_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dev_sel = 1'b0;
  logic        lba_mode = 1'b0;
  logic [26:0] lba_addr = '0;
  logic [7:0]  sect_cnt = '0;
  logic [7:0]  feat_val = '0;
  logic [7:0]  cmd_code = '0;
  logic        clk_fast = 1'b0;
  logic [15:0] poll_limit = 16'd200;
  logic        reg_rd, reg_wr;
  logic [3:0]  reg_sel;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata = 8'h00;
  logic        drv_irq = 1'b0;
  logic        busy, done, accepted, cmd_error, timeout;

  always #4 clk = ~clk;

  ata_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel), .lba_mode(lba_mode),
    .lba_addr(lba_addr), .sect_cnt(sect_cnt), .feat_val(feat_val), .cmd_code(cmd_code),
    .clk_fast(clk_fast), .poll_limit(poll_limit), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_irq(drv_irq),
    .busy(busy), .done(done), .accepted(accepted), .cmd_error(cmd_error), .timeout(timeout)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- drive model ----------------
  int pre_left = 0, post_left = 0, irq_cnt = 0;
  bit sel_seen = 0, cmd_seen = 0, err_on = 0;

  always @(posedge clk) begin
    if (reg_wr && reg_sel == 4'd6) sel_seen <= 1'b1;
    if (reg_wr && reg_sel == 4'd7) begin cmd_seen <= 1'b1; irq_cnt <= 3; end
    if (irq_cnt > 0) begin
      if (irq_cnt == 1) drv_irq <= 1'b1;
      irq_cnt <= irq_cnt - 1;
    end
    if (reg_rd) begin
      if (cmd_seen) begin
        reg_rdata <= err_on ? 8'h41 : 8'h40;
        drv_irq   <= 1'b0;
      end else if (!sel_seen) begin
        if (pre_left > 0) begin
          reg_rdata <= pre_left[0] ? 8'h80 : 8'h08;
          pre_left  <= pre_left - 1;
        end else reg_rdata <= 8'h40;
      end else begin
        if (post_left > 0) begin
          reg_rdata <= post_left[0] ? 8'h80 : 8'h08;
          post_left <= post_left - 1;
        end else reg_rdata <= 8'h40;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [11:0] v; string req; } exp_t;
  exp_t exp_q[$];
  int   cyc = 0, wr_cyc = 0, exp_gap = 0, done_cnt = 0;
  bit   gap_armed = 0, dev_pending = 0, first_pending = 0;

  function automatic void push(logic [3:0] s, logic [7:0] d, string r);
    exp_t e;
    e.v = {s, d};
    e.req = r;
    exp_q.push_back(e);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (reg_rd && reg_wr) chk(0, "R10", "both strobes", 1, 0);
      if (first_pending && (reg_rd || reg_wr)) begin
        chk(reg_rd && reg_sel == 4'd8, "R3", "first strobe is status read", {reg_wr, reg_sel}, 8);
        first_pending = 0;
      end
      if (reg_wr) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected write", {reg_sel, reg_wdata}, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({reg_sel, reg_wdata} == e.v, e.req, "write sel/data", {reg_sel, reg_wdata}, e.v);
        end
        if (dev_pending && reg_sel == 4'd6) begin
          wr_cyc = cyc; gap_armed = 1; dev_pending = 0;
        end else gap_armed = 0;
      end
      if (reg_rd && gap_armed) begin
        chk(cyc - wr_cyc == exp_gap, "R5", "settle gap cycles", cyc - wr_cyc, exp_gap);
        gap_armed = 0;
      end
      if (done) done_cnt++;
    end
  end

  // kind: 0 accepted, 1 error, 2 timeout in first poll, 3 timeout in second poll
  task automatic run_cmd(bit dv, bit md, logic [26:0] la, logic [7:0] sc, logic [7:0] ft,
                         logic [7:0] cm, bit fs, int pre, int post, bit er,
                         logic [15:0] lim, int kind, bit glitch);
    logic [7:0] dh;
    int d0;
    bit got_done, got_acc, got_err, got_to;
    dh = {1'b1, md, 1'b1, dv, 4'b0000};
    @(negedge clk);
    pre_left = pre; post_left = post; err_on = er;
    sel_seen = 0; cmd_seen = 0;
    if (kind != 2) push(4'd6, dh, "R4");
    if (kind <= 1) begin
      push(4'd1, ft, "R7"); push(4'd2, sc, "R7");
      push(4'd3, la[7:0], "R7"); push(4'd4, la[15:8], "R7"); push(4'd5, la[23:16], "R7");
      push(4'd6, {dh[7:4], 1'b0, la[26:24]}, "R7");
      push(4'd7, cm, "R7");
    end
    exp_gap = fs ? 54 : 28;
    dev_pending = 1; first_pending = 1;
    d0 = done_cnt;
    dev_sel = dv; lba_mode = md; lba_addr = la; sect_cnt = sc; feat_val = ft;
    cmd_code = cm; clk_fast = fs; poll_limit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (glitch) begin
      repeat (10) @(negedge clk);
      dev_sel = ~dv; lba_mode = ~md; lba_addr = ~la; feat_val = ~ft;
      cmd_code = ~cm; clk_fast = ~fs;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy holds through ignored start", busy, 1);
    end
    got_done = 0; got_acc = 0; got_err = 0; got_to = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done || timeout) begin
        got_done = done; got_acc = accepted; got_err = cmd_error; got_to = timeout;
        chk(busy == 1'b0, kind >= 2 ? "R9" : "R8", "busy low at finish", busy, 0);
        break;
      end
      @(negedge clk);
    end
    chk(got_done == (kind <= 1), kind >= 2 ? "R9" : "R8", "done pulse", got_done, kind <= 1);
    chk(got_acc == (kind == 0), "R8", "accepted", got_acc, kind == 0);
    chk(got_err == (kind == 1), "R8", "cmd_error", got_err, kind == 1);
    chk(got_to == (kind >= 2), "R9", "timeout", got_to, kind >= 2);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "writes outstanding", exp_q.size(), 0);
    chk(done_cnt - d0 == (kind <= 1 ? 1 : 0), "R2", "done count", done_cnt - d0, kind <= 1);
    chk(!busy && !timeout && !done, "R9", "quiet after finish", {busy, timeout, done}, 0);
    exp_q.delete();
    gap_armed = 0; dev_pending = 0; first_pending = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !reg_rd && !reg_wr, "R1", "strobes/busy in reset", {busy, reg_rd, reg_wr}, 0);
    chk(!done && !accepted && !cmd_error && !timeout, "R1", "results in reset",
        {done, accepted, cmd_error, timeout}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !reg_rd && !reg_wr, "R1", "idle after reset", {busy, reg_rd, reg_wr}, 0);

    // R3 R4 R5 R7 R8: drive 0, LBA, 66 MHz setting, ready at once
    run_cmd(0, 1, 27'h5A3C1E7, 8'h10, 8'h03, 8'hC8, 0, 0, 0, 0, 16'd200, 0, 0);
    // R3 with BSY/DRQ waits, R5 132 MHz setting, drive 1, CHS mode
    run_cmd(1, 0, 27'h2123456, 8'h01, 8'h00, 8'h20, 1, 5, 3, 0, 16'd200, 0, 0);
    // R8 error reported
    run_cmd(0, 1, 27'h7FFFFFF, 8'hFF, 8'hAA, 8'h30, 0, 2, 0, 1, 16'd200, 1, 0);
    // R9 timeout in first poll
    run_cmd(1, 1, 27'h0000001, 8'h02, 8'h00, 8'h25, 0, 100000, 0, 0, 16'd10, 2, 0);
    // R9 timeout in second poll
    run_cmd(0, 1, 27'h1234567, 8'h02, 8'h00, 8'h25, 1, 0, 100000, 0, 16'd10, 3, 0);
    // R2 R6 start while busy ignored, clock select flipped mid-command
    run_cmd(1, 1, 27'h3C0FFEE, 8'h08, 8'h05, 8'hCA, 0, 1, 1, 0, 16'd200, 0, 1);
    // R9 zero limit still lets a ready drive through
    run_cmd(0, 0, 27'h0000000, 8'h00, 8'h00, 8'hEC, 1, 0, 0, 0, 16'd0, 0, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule